// File: doc/BRIEF.md
# Serial-to-Byte Readback Controller

This controller sits on the host side of a chain of serial converter ports and turns their bit stream into bytes. Each converter in the chain holds a 40-bit frame. The chain marks that fresh data is waiting by pulling an active-low ready line. Once ready has been seen low, a user request starts a readback. The controller pulls the active-low transmit line low on a falling edge of the system clock. It then gates the system clock onto the data clock, so the data clock is low at the moment transmit falls.

The chain changes its output on falling data-clock edges, and the controller samples it on rising edges. Bits are collected eight at a time, MSB first, into a serial-in/parallel-out register. After each group of eight the data clock stops. The byte is shown with a one-cycle valid strobe, and the next group starts only after an acknowledge. After `5 × N_DEV` bytes the controller gives a one-cycle done pulse and releases transmit. A new request then has no effect until ready has been seen low again.

Top module: `byte_readback_ctrl`

## Requirements
- R1: While reset is asserted and right after it, xmit_n is 1, dclk is 0, and byte_valid and done are 0.
- R2: A request raised before ready_n has been seen low since reset leaves xmit_n at 1 and produces no dclk edge.
- R3: xmit_n falls only at a falling clk edge, with dclk low at that instant. The first rising dclk edge follows half a clk period later.
- R4: sdata is sampled on rising dclk edges. The first bit of each group of eight becomes byte_out[7] and the last becomes byte_out[0].
- R5: Each group contains exactly 8 rising dclk edges. dclk then stays low while the byte is shown.
- R6: byte_valid is high for exactly one clk cycle per byte, and byte_out keeps its value until the next group starts.
- R7: After a non-final byte, no dclk edge occurs until ack has been sampled high, however long ack is withheld.
- R8: After byte number 5 × N_DEV, done pulses for one cycle and xmit_n returns to 1 in the same cycle.
- R9: xmit_n stays 0 for the whole frame, including every pause between groups.
- R10: After done, a held request starts nothing until ready_n is seen low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_n | input | 1 | Chain data-ready, active low |
| req | input | 1 | User readback request |
| ack | input | 1 | Host has taken the shown byte |
| sdata | input | 1 | Serial data from the end of the chain |
| xmit_n | output | 1 | Transmit enable to the chain, active low |
| dclk | output | 1 | Gated data clock to the chain |
| byte_out | output | 8 | Last collected byte, first bit in MSB |
| byte_valid | output | 1 | One-cycle strobe for byte_out |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The assertions check several properties on every cycle. The data clock never runs while transmit is high. It is stopped whenever a byte is shown. The valid and done strobes last one cycle each. Transmit is released right after done. Other properties depend on whole sequences, so only the bench scenarios can show them: half-cycle placement of the first data-clock edge relative to the transmit fall, exact eight-edge groups, MSB-first byte assembly against a modelled chain, pauses held over long acknowledge delays, and requests ignored before ready and after done.

// File: rtl/byte_readback_ctrl.sv
module byte_readback_ctrl #(
  parameter int N_DEV         = 3,
  parameter int BYTES_PER_DEV = 5,
  parameter int BYTE_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_n,
  input  logic              req,
  input  logic              ack,
  input  logic              sdata,
  output logic              xmit_n,
  output logic              dclk,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              done
);
  localparam int NBYTES = N_DEV * BYTES_PER_DEV;
  localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int BW     = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_SHOW, S_HOLD, S_DONE} st_t;

  st_t              st;
  logic             armed, en_q, xmit_q;
  logic [BW-1:0]    bcnt;
  logic [CW-1:0]    ycnt;
  logic [BYTE_W-1:0] sr;

  logic start, last_bit, last_byte;
  assign start     = (st == S_IDLE) && req && armed;
  assign last_bit  = (bcnt == BW'(BYTE_W - 1));
  assign last_byte = (ycnt == CW'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      armed <= 1'b0;
      bcnt  <= '0;
      ycnt  <= '0;
      sr    <= '0;
    end else begin
      if (start)
        armed <= 1'b0;
      else if (st == S_IDLE && !ready_n)
        armed <= 1'b1;
      if (en_q) begin
        sr   <= {sr[BYTE_W-2:0], sdata};
        bcnt <= last_bit ? '0 : bcnt + 1'b1;
      end
      case (st)
        S_IDLE:  if (start) begin st <= S_SHIFT; ycnt <= '0; end
        S_SHIFT: if (en_q && last_bit) st <= S_SHOW;
        S_SHOW:  begin
                   ycnt <= ycnt + 1'b1;
                   st   <= last_byte ? S_DONE : S_HOLD;
                 end
        S_HOLD:  if (ack) st <= S_SHIFT;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      xmit_q <= 1'b0;
    end else begin
      en_q   <= (st == S_SHIFT);
      xmit_q <= (st == S_SHIFT) || (st == S_SHOW) || (st == S_HOLD);
    end
  end

  assign xmit_n     = ~xmit_q;
  assign dclk       = clk & en_q;
  assign byte_out   = sr;
  assign byte_valid = (st == S_SHOW);
  assign done       = (st == S_DONE);
endmodule

// File: rtl/byte_readback_ctrl_chk.sv
module byte_readback_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic xmit_n,
  input logic byte_valid,
  input logic done,
  input logic en_q
);
  AST_CLK_NEEDS_XMIT: assert property (@(posedge clk) disable iff (!rst_n) en_q |-> !xmit_n); // R9
  AST_PAUSE_ON_SHOW:  assert property (@(posedge clk) disable iff (!rst_n) byte_valid |-> (!en_q && !xmit_n)); // R5
  AST_VALID_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) byte_valid |=> !byte_valid); // R6
  AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_RELEASE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (xmit_n && !en_q)); // R8
endmodule

bind byte_readback_ctrl byte_readback_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xmit_n(xmit_n),
  .byte_valid(byte_valid), .done(done), .en_q(en_q)
);

// File: tb/test_byte_readback_ctrl.sv
`timescale 1ns/1ps
module test_byte_readback_ctrl;
  localparam int NDEV  = 3;
  localparam int NB    = NDEV * 5;
  localparam int TOTAL = NB * 8;

  logic clk = 1'b0, rst_n = 1'b0, ready_n = 1'b1, req = 1'b0, ack = 1'b0;
  logic sdata, xmit_n, dclk, byte_valid, done;
  logic [7:0] byte_out;

  logic [0:TOTAL-1] bits;
  int idx = 0, base = 0, rises = 0, mark = 0;
  int n_chk = 0, n_fail = 0;
  time t_fall = 0, t_first = 0, last_rise = 0;
  logic fall_ok = 1'b1;

  always #2 clk = ~clk;

  byte_readback_ctrl i_byte_readback_ctrl (
    .clk(clk), .rst_n(rst_n), .ready_n(ready_n), .req(req), .ack(ack),
    .sdata(sdata), .xmit_n(xmit_n), .dclk(dclk), .byte_out(byte_out),
    .byte_valid(byte_valid), .done(done)
  );

  assign sdata = (!xmit_n && (idx - base) < TOTAL && (idx - base) >= 0) ? bits[idx - base] : 1'b1;

  always @(negedge dclk) if (!xmit_n) idx++;
  always @(posedge dclk) begin
    rises++;
    if (last_rise < t_fall) t_first = $time;
    last_rise = $time;
  end
  always @(negedge xmit_n) begin
    t_fall  = $time;
    fall_ok = (clk == 1'b0) && (dclk == 1'b0);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic logic [7:0] exp_byte(input int j);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = bits[8*j + k];
    return b;
  endfunction

  task automatic run_frame(input int maxd, input bit long_pause);
    int n;
    for (int w = 0; w < TOTAL/32; w++) bits[w*32 +: 32] = $urandom;
    base = idx;
    mark = rises;
    tick(); ready_n = 1'b0;
    repeat (2) tick();
    req = 1'b1;
    n = 0;
    while (xmit_n && n < 20) begin tick(); n++; end
    ready_n = 1'b1;
    check(!xmit_n, "R3 xmit start", xmit_n, 0);
    for (int j = 0; j < NB; j++) begin
      n = 0;
      while (!byte_valid && n < 100) begin tick(); n++; end
      req = 1'b0;
      if (j == 0) begin
        check(fall_ok, "R3 clk/dclk low at xmit fall", fall_ok, 1);
        check(t_first - t_fall == 2, "R3 first dclk rise", t_first - t_fall, 2);
      end
      check(byte_valid, "R6 valid seen", byte_valid, 1);
      check(byte_out == exp_byte(j), "R4 byte value", byte_out, exp_byte(j));
      check(rises - mark == 8, "R5 edges per group", rises - mark, 8);
      check(!xmit_n, "R9 xmit low at byte", xmit_n, 0);
      mark = rises;
      tick();
      if (j < NB - 1) begin
        check(!byte_valid, "R6 valid one cycle", byte_valid, 0);
        check(byte_out == exp_byte(j), "R6 byte held", byte_out, exp_byte(j));
        repeat ((long_pause && j == 2) ? 20 : ($urandom % (maxd + 1))) tick();
        check(rises == mark, "R7 no dclk before ack", rises - mark, 0);
        check(!xmit_n, "R9 xmit low in pause", xmit_n, 0);
        ack = 1'b1; tick(); ack = 1'b0;
      end else begin
        check(done, "R8 done pulse", done, 1);
        check(xmit_n, "R8 xmit released", xmit_n, 1);
        tick();
        check(!done, "R8 done one cycle", done, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    bits = '0;
    #1;
    check(xmit_n && !dclk && !byte_valid && !done, "R1 in reset", {xmit_n, dclk, byte_valid, done}, 4'b1000);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(xmit_n && !dclk && !byte_valid && !done, "R1 after reset", {xmit_n, dclk, byte_valid, done}, 4'b1000);
    mark = rises;
    req = 1'b1;
    repeat (10) tick();
    check(xmit_n, "R2 request before ready", xmit_n, 1);
    check(rises == mark, "R2 no dclk before ready", rises - mark, 0);
    req = 1'b0;
    run_frame(0, 1'b0);
    run_frame(4, 1'b1);
    for (int f = 0; f < 4; f++) run_frame(1 + f, 1'b0);
    mark = rises;
    req = 1'b1;
    repeat (20) tick();
    check(xmit_n, "R10 request after done", xmit_n, 1);
    check(rises == mark, "R10 no dclk after done", rises - mark, 0);
    req = 1'b0;
    run_frame(2, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 4);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule